// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block is the receive half of a synchronous serial port running as a slave: an external master drives both the serial clock and the data line, and the block assembles the incoming bits into words of 8 bits, or 9 bits when the ninth-bit option is on. Both external lines pass through a synchronizer into the system clock domain. Data is sampled on each rising edge of the external clock, least significant bit first. A finished word goes into a two-entry holding queue. A receive-complete flag stays high while any unread word remains, and it can raise an interrupt request.

Because the master supplies the clock, reception needs no baud-rate logic and keeps running while the host is idle or asleep. The interrupt request is what wakes the host. The host reads words through a one-cycle read strobe. It turns reception on and off with a continuous-receive enable, and clearing that enable is also the only way to clear an overrun. A single-shot receive enable input exists for register compatibility and has no effect in this mode. The framing-error status is always zero here because synchronous frames carry no stop bit.

Top module: `sync_slave_rx`

## Requirements
- R1: Reception is active only when `port_en_i`=1, `sync_mode_i`=1, `clk_master_i`=0 and `cont_en_i`=1. In any other combination no word is stored, and the bit count, partial word and overrun flag are held clear.
- R2: `single_en_i` has no effect on reception or on any output.
- R3: Each rising edge of `ext_clk_i` samples `ext_dat_i`, after a two-stage synchronizer. The first bit sampled goes to bit 0. In 8-bit mode (`nine_bit_i`=0) the eighth sample completes a word, which then appears on `rd_data_o` three system clocks after the external rising edge.
- R4: With `nine_bit_i`=1 a word is 9 samples long. The ninth (last) sample appears on `bit9_o` next to the 8-bit data. In 8-bit mode `bit9_o` is 0.
- R5: `rx_done_o` is high while at least one unread word is held. `rd_data_o`/`bit9_o` show the oldest unread word, and both read 0 when nothing is held. A high `rd_i` at a clock edge removes the oldest word.
- R6: `irq_o` is high exactly when `irq_en_i`=1 and `rx_done_o`=1. It needs no system-side activity beyond the clock.
- R7: Up to two unread words are held, counting a read in the same cycle as freeing a slot. A word that completes with no free slot sets `overrun_o` and is discarded. While `overrun_o` is high, every further completed word is discarded.
- R8: Driving `cont_en_i` low clears `overrun_o`, the bit count and any partial word on the next edge. Words already held remain readable, and the next word after re-enable starts at bit 0.
- R9: `frame_err_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | Serial clock from the external master |
| ext_dat_i | input | 1 | Serial data from the external master |
| port_en_i | input | 1 | Serial port enable |
| sync_mode_i | input | 1 | Synchronous mode select |
| clk_master_i | input | 1 | Clock-source select; 0 = external clock (slave) |
| cont_en_i | input | 1 | Continuous-receive enable; low clears errors |
| single_en_i | input | 1 | Single-shot receive enable (ignored) |
| nine_bit_i | input | 1 | 1 = 9-bit words |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Read strobe for the data register |
| rd_data_o | output | 8 | Oldest unread data byte |
| bit9_o | output | 1 | Ninth bit of the oldest unread word |
| frame_err_o | output | 1 | Framing error status (always 0) |
| overrun_o | output | 1 | Overrun error status |
| rx_done_o | output | 1 | Receive-complete flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its default parameters: 8 data bits, a two-stage synchronizer and a two-word queue. The queue depth of two lets a third unsent-read word reach the overrun path within a few hundred cycles. The synchronizer depth fixes the three-cycle delay that the bench's reference model shifts its external-clock history by. With a byte width of 8, both the 8-bit and 9-bit framings and the ninth-bit status can be checked against exact byte values.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  typedef enum logic [1:0] {
    RX_OFF   = 2'd0,
    RX_SHIFT = 2'd1,
    RX_STALL = 2'd2
  } rx_mode_e;

  // Index of the last sample of a word for the chosen framing.
  function automatic int unsigned last_bit_idx(input logic nine, input int unsigned data_w);
    return nine ? data_w : data_w - 1;
  endfunction

  // Pointer advance with wrap at an arbitrary depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/sync_rx_edge.sv
module sync_rx_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_i,
  input  logic ext_dat_i,
  output logic rise_o,
  output logic dat_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [1:0] stg_q [SYNC_STAGES];
  logic       prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= {ext_dat_i, ext_clk_i};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stg_q[LAST][0];
  end

  assign rise_o = stg_q[LAST][0] & ~prev_q;
  assign dat_o  = stg_q[LAST][1];

  // R3: a detected edge lasts one system cycle
  p_rise_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on_i,
  input  logic              nine_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              word_done_o,
  output logic [DATA_W:0]   word_o
);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(last_bit_idx(1'b1, DATA_W));
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(last_bit_idx(1'b0, DATA_W));

  logic [DATA_W:0]  part_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx    = nine_i ? LAST9 : LAST8;
  assign word_done_o = rx_on_i & rise_i & (cnt_q >= last_idx);

  always_comb begin
    for (int i = 0; i <= int'(DATA_W); i++) begin
      word_o[i] = (CNT_W'(i) == cnt_q) ? bit_i : part_q[i];
    end
    if (!nine_i) word_o[DATA_W] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else if (!rx_on_i) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else if (rise_i) begin
      if (word_done_o) begin
        cnt_q  <= '0;
        part_q <= '0;
      end else begin
        part_q[cnt_q] <= bit_i;
        cnt_q         <= cnt_q + 1'b1;
      end
    end
  end

  // R4: the count never runs past the ninth sample
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST9);

  // R8: disabling reception restarts the word
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on_i |=> (cnt_q == '0));

endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
  import sync_rx_pkg::*;
#(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic             empty_o,
  output logic             room_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok, push_ok;

  assign empty_o = (cnt_q == '0);
  assign pop_ok  = pop_i & ~empty_o;
  assign room_o  = (cnt_q != FULL_CNT) | pop_ok;
  assign push_ok = push_i & room_o;
  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= wdata_i;
        wr_q        <= PTR_W'(wrap_inc(32'(wr_q), DEPTH));
      end
      if (pop_ok) rd_q <= PTR_W'(wrap_inc(32'(rd_q), DEPTH));
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // R7: never more than DEPTH unread words
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R5: a stored word is visible on the next cycle
  p_fill_shows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> !empty_o);

endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEPTH       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_i,
  input  logic              ext_dat_i,
  input  logic              port_en_i,
  input  logic              sync_mode_i,
  input  logic              clk_master_i,
  input  logic              cont_en_i,
  input  logic              single_en_i,
  input  logic              nine_bit_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              bit9_o,
  output logic              frame_err_o,
  output logic              overrun_o,
  output logic              rx_done_o,
  output logic              irq_o
);
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  rx_mode_e          mode;
  logic              rx_on;
  logic              rise, sbit;
  logic              word_done;
  logic [WORD_W-1:0] word, head;
  logic              empty, room, push;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              overrun_q;
  logic              unused_single;

  assign unused_single = single_en_i;

  always_comb begin
    if (!(port_en_i && sync_mode_i && !clk_master_i && cont_en_i)) mode = RX_OFF;
    else if (overrun_q)                                            mode = RX_STALL;
    else                                                           mode = RX_SHIFT;
  end
  assign rx_on = (mode != RX_OFF);

  sync_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk_i (ext_clk_i),
    .ext_dat_i (ext_dat_i),
    .rise_o    (rise),
    .dat_o     (sbit)
  );

  sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_on_i     (rx_on),
    .nine_i      (nine_bit_i),
    .rise_i      (rise),
    .bit_i       (sbit),
    .word_done_o (word_done),
    .word_o      (word)
  );

  assign push = word_done & (mode == RX_SHIFT);

  sync_rx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .wdata_i (word),
    .pop_i   (rd_i),
    .rdata_o (head),
    .empty_o (empty),
    .room_o  (room),
    .count_o (fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         overrun_q <= 1'b0;
    else if (!rx_on)                    overrun_q <= 1'b0;
    else if (word_done && !room)        overrun_q <= 1'b1;
  end

  assign rx_done_o   = ~empty;
  assign rd_data_o   = empty ? '0 : head[DATA_W-1:0];
  assign bit9_o      = empty ? 1'b0 : head[DATA_W];
  assign overrun_o   = overrun_q;
  assign frame_err_o = 1'b0;
  assign irq_o       = irq_en_i & rx_done_o;

  // R7: words finishing during an overrun never enter the queue
  p_stall_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && overrun_q && !rd_i) |=> (fifo_cnt == $past(fifo_cnt)));

  // R8: dropping the continuous enable clears the error
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en_i |=> !overrun_o);

  // R1: nothing is stored while the port is not a receiving slave
  p_off_no_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en_i && !rd_i) |=> (fifo_cnt <= $past(fifo_cnt)));

endmodule

// File: tb/sync_slave_rx_tb.sv
`timescale 1ns/1ps
module sync_slave_rx_tb;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0, ext_dat = 1'b0;
  logic port_en = 1'b0, sync_mode = 1'b0, clk_master = 1'b0, cont_en = 1'b0;
  logic single_en = 1'b0, nine_bit = 1'b0, irq_en = 1'b0, rd = 1'b0;
  logic [7:0] rd_data;
  logic bit9, frame_err, overrun, rx_done, irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int  mq[$];
  int  mcnt = 0, mword = 0;
  bit  movr = 0;
  bit  h1c = 0, h2c = 0, h3c = 0, h1d = 0, h2d = 0;

  always #2 clk = ~clk;

  sync_slave_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .ext_dat_i(ext_dat),
    .port_en_i(port_en), .sync_mode_i(sync_mode), .clk_master_i(clk_master),
    .cont_en_i(cont_en), .single_en_i(single_en), .nine_bit_i(nine_bit),
    .irq_en_i(irq_en), .rd_i(rd), .rd_data_o(rd_data), .bit9_o(bit9),
    .frame_err_o(frame_err), .overrun_o(overrun), .rx_done_o(rx_done), .irq_o(irq)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model_edge();
    bit on, rise, b;
    int len;
    on   = port_en && sync_mode && !clk_master && cont_en;
    rise = h2c && !h3c;
    b    = h2d;
    len  = nine_bit ? 9 : 8;
    if (rd && mq.size() > 0) void'(mq.pop_front());
    if (!on) begin
      mcnt = 0; mword = 0; movr = 0;
    end else if (rise) begin
      mword = mword | (int'(b) << mcnt);
      if (mcnt >= len - 1) begin
        if (!nine_bit) mword = mword & 'hFF;
        if (!movr) begin
          if (mq.size() < DEPTH) mq.push_back(mword);
          else movr = 1;
        end
        mcnt = 0; mword = 0;
      end else begin
        mcnt++;
      end
    end
    h3c = h2c; h2c = h1c; h1c = ext_clk;
    h2d = h1d; h1d = ext_dat;
  endtask

  task automatic compare_all();
    int head;
    head = (mq.size() > 0) ? mq[0] : 0;
    chk("R5", "rx_done", int'(rx_done), int'(mq.size() > 0));
    chk("R3", "rd_data", int'(rd_data), head & 'hFF);
    chk("R4", "bit9", int'(bit9), (head >> 8) & 1);
    chk("R7", "overrun", int'(overrun), int'(movr));
    chk("R6", "irq", int'(irq), int'(irq_en && mq.size() > 0));
    chk("R9", "frame_err", int'(frame_err), 0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send_word(input int value, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ext_clk = 1'b0; ext_dat = value[i];
      steps(3);
      ext_clk = 1'b1;
      steps(3);
    end
    steps(2);
  endtask

  task automatic read_word();
    rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic slave_on();
    port_en = 1'b1; sync_mode = 1'b1; clk_master = 1'b0; cont_en = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R5", "reset rx_done", int'(rx_done), 0);
    chk("R7", "reset overrun", int'(overrun), 0);
    chk("R6", "reset irq", int'(irq), 0);
    chk("R9", "reset frame_err", int'(frame_err), 0);

    // R3: plain 8-bit word, LSB first
    slave_on();
    steps(4);
    send_word('hA5, 8);
    chk("R3", "byte A5", int'(rd_data), 'hA5);
    chk("R6", "irq masked", int'(irq), 0);
    read_word();
    chk("R5", "cleared by read", int'(rx_done), 0);

    // R6: interrupt request
    irq_en = 1'b1;
    send_word('h3C, 8);
    chk("R6", "irq raised", int'(irq), 1);
    read_word();
    chk("R6", "irq dropped", int'(irq), 0);

    // R4: nine-bit framing
    nine_bit = 1'b1;
    send_word('h15A, 9);
    chk("R4", "nine data", int'(rd_data), 'h5A);
    chk("R4", "nine bit set", int'(bit9), 1);
    read_word();
    send_word('h081, 9);
    chk("R4", "nine bit clear", int'(bit9), 0);
    chk("R4", "nine data 81", int'(rd_data), 'h81);
    read_word();
    nine_bit = 1'b0;

    // R2: single-shot enable cannot start reception, nor alter it
    cont_en = 1'b0; single_en = 1'b1;
    steps(2);
    send_word('h77, 8);
    chk("R2", "single alone ignored", int'(rx_done), 0);
    cont_en = 1'b1;
    send_word('h5E, 8);
    chk("R2", "single no effect", int'(rd_data), 'h5E);
    read_word();
    single_en = 1'b0;

    // R1: not a slave -> nothing stored
    clk_master = 1'b1;
    send_word('h11, 8);
    chk("R1", "master select", int'(rx_done), 0);
    clk_master = 1'b0; sync_mode = 1'b0;
    send_word('h22, 8);
    chk("R1", "async select", int'(rx_done), 0);
    sync_mode = 1'b1; port_en = 1'b0;
    send_word('h33, 8);
    chk("R1", "port off", int'(rx_done), 0);
    port_en = 1'b1;
    steps(2);

    // R7: overrun on third unread word
    send_word('h01, 8);
    send_word('h02, 8);
    chk("R7", "two held no error", int'(overrun), 0);
    send_word('h03, 8);
    chk("R7", "overrun set", int'(overrun), 1);
    chk("R7", "oldest kept", int'(rd_data), 'h01);
    read_word();
    chk("R7", "second kept", int'(rd_data), 'h02);
    read_word();
    chk("R7", "third discarded", int'(rx_done), 0);
    send_word('h04, 8);
    chk("R7", "stalled discard", int'(rx_done), 0);

    // R8: clear by dropping enable, partial word discarded
    cont_en = 1'b0; step();
    chk("R8", "overrun cleared", int'(overrun), 0);
    cont_en = 1'b1;
    send_word('h0F, 4);
    cont_en = 1'b0; steps(2); cont_en = 1'b1;
    send_word('h96, 8);
    chk("R8", "clean restart", int'(rd_data), 'h96);
    send_word('h4B, 8);
    cont_en = 1'b0; step();
    chk("R8", "held words kept", int'(rd_data), 'h96);
    cont_en = 1'b1;
    read_word(); read_word();

    // R5/R7: read in the same cycle a third word lands
    send_word('hC1, 8);
    send_word('hC2, 8);
    send_word('hC3, 7);
    ext_clk = 1'b0; ext_dat = 1'b1; steps(3);
    ext_clk = 1'b1; steps(2);
    read_word();
    steps(2);
    chk("R7", "read frees slot", int'(overrun), 0);
    chk("R5", "next head", int'(rd_data), 'hC2);
    read_word();
    chk("R5", "late word", int'(rd_data), 'hC3);
    read_word();
    steps(4);
    summary();
  end

endmodule